// File: doc/BRIEF.md
# Ring-Counter Instruction Control Sequencer

This block generates the per-step control strobes for a small accumulator machine whose registers share one data bus. A one-hot ring of step flags advances on every clock edge. A decoder turns the opcode held in the instruction register into one of three one-hot instruction lines: load, store and undefined. Each strobe is an OR of AND terms, and each term pairs one instruction line with one step flag. When the current instruction reaches its last step, the ring goes back to its first position, so a short instruction spends no idle cycles.

Every instruction opens with the same three-step fetch. In the first step the program counter drives the bus and the memory address register captures it. In the second step the instruction register loads from memory. In the third step the program counter increments. A load then addresses the operand byte and copies it into the accumulator. A store addresses its target, then drives the accumulator onto the bus with the write strobe high. Any other opcode ends after the fetch. The instruction register itself sits outside this block, and its output feeds `ir_opcode`.

Top module: `step_sequencer`

## Requirements
- R1: While `rst` is high every strobe output is 0. On the first clock edge with `rst` high the ring goes to step 0 (`step` = 6'b000001). Right after `rst` falls the step-0 strobes are present.
- R2: `step` is one-hot at all times. Bit i is step Ti. Each clock edge moves the active bit up one position, except when the ring restarts at T0.
- R3: `op_line` is one-hot. Bit 0 is high for opcode 0 (load), bit 1 for opcode 1 (store), and bit 2 for every other opcode value.
- R4: Fetch is the same for every opcode. T0 asserts `pc_out` and `mar_load` only. T1 asserts `ir_load` only. T2 asserts `pc_inc` only.
- R5: Load: T3 asserts `pc_out` and `mar_load`. T4 asserts `acc_load` and `pc_inc`. The next cycle is T0, so a load takes 5 cycles.
- R6: Store: T3 asserts `pc_out` and `mar_load`. T4 asserts `pc_inc`. T5 asserts `acc_out` and `mem_write`. The next cycle is T0, so a store takes 6 cycles.
- R7: An undefined opcode asserts no strobe after T2, and the cycle after T2 is T0, so it takes 3 cycles.
- R8: `mem_write` is high only during store T5. In every other step it stays low.
- R9: `pc_out` and `acc_out` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ir_opcode | input | OPW | Instruction register contents |
| step | output | 6 | One-hot step ring |
| op_line | output | 3 | One-hot decoded instruction: {undefined, store, load} |
| pc_out | output | 1 | Program counter drives the bus |
| mar_load | output | 1 | Memory address register captures the bus |
| ir_load | output | 1 | Instruction register captures memory data |
| pc_inc | output | 1 | Program counter increments |
| acc_load | output | 1 | Accumulator captures memory data |
| acc_out | output | 1 | Accumulator drives the bus |
| mem_write | output | 1 | Read/write select: 1 writes, 0 reads |

## Verification
Two things meet in the final step of every instruction. The last execute strobes (for a load, `acc_load` together with `pc_inc`) are asserted, and the early ring restart is decided in that same cycle. The scoreboard checks that the cycle after that step is T0 with the fetch strobes present, and it runs a mixed stream of back-to-back loads, stores and undefined opcodes. A second collision is forced on purpose: reset is raised during a load's final step. The bench then requires all strobes to drop at once and step 0 to be present when reset is released.

// File: rtl/step_sequencer.sv
module step_sequencer #(
  parameter int OPW        = 8,
  parameter int LOAD_CODE  = 0,
  parameter int STORE_CODE = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] ir_opcode,
  output logic [5:0]     step,
  output logic [2:0]     op_line,
  output logic           pc_out,
  output logic           mar_load,
  output logic           ir_load,
  output logic           pc_inc,
  output logic           acc_load,
  output logic           acc_out,
  output logic           mem_write
);
  localparam int FETCH_LEN = 3;
  localparam int LOAD_LEN  = 5;
  localparam int STORE_LEN = 6;
  localparam int RING      = (LOAD_LEN > STORE_LEN) ? LOAD_LEN : STORE_LEN;

  logic [RING-1:0] ring;
  logic is_ld, is_st, is_un, done, run;

  assign is_ld   = (ir_opcode == OPW'(LOAD_CODE));
  assign is_st   = (ir_opcode == OPW'(STORE_CODE));
  assign is_un   = ~(is_ld | is_st);
  assign op_line = {is_un, is_st, is_ld};

  assign done = (is_un & ring[FETCH_LEN-1])
              | (is_ld & ring[LOAD_LEN-1])
              | (is_st & ring[STORE_LEN-1]);

  always_ff @(posedge clk) begin
    if (rst || done) ring <= RING'(1);
    else             ring <= {ring[RING-2:0], ring[RING-1]};
  end

  assign step = ring;
  assign run  = ~rst;

  assign pc_out    = run & (ring[0] | ((is_ld | is_st) & ring[3]));
  assign mar_load  = run & (ring[0] | ((is_ld | is_st) & ring[3]));
  assign ir_load   = run & ring[1];
  assign pc_inc    = run & (ring[2] | ((is_ld | is_st) & ring[4]));
  assign acc_load  = run & is_ld & ring[4];
  assign acc_out   = run & is_st & ring[5];
  assign mem_write = run & is_st & ring[5];
endmodule

// File: rtl/step_sequencer_chk.sv
module step_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic [5:0] step,
  input logic [2:0] op_line,
  input logic       pc_out,
  input logic       mar_load,
  input logic       ir_load,
  input logic       pc_inc,
  input logic       acc_load,
  input logic       acc_out,
  input logic       mem_write
);
  logic [6:0] strb;
  assign strb = {pc_out, mar_load, ir_load, pc_inc, acc_load, acc_out, mem_write};

  assert_reset_quiet_R1: assert property (@(posedge clk) rst |-> strb == 7'b0);
  assert_reset_t0_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> step == 6'b000001);
  assert_ring_onehot_R2: assert property (@(posedge clk) disable iff (rst) $onehot(step));
  assert_ring_shift_R2: assert property (@(posedge clk) disable iff (rst)
    !step[0] |-> step == ($past(step) << 1));
  assert_decode_onehot_R3: assert property (@(posedge clk) disable iff (rst) $onehot(op_line));
  assert_load_restart_R5: assert property (@(posedge clk) disable iff (rst)
    $past(acc_load) |-> step[0]);
  assert_store_restart_R6: assert property (@(posedge clk) disable iff (rst)
    $past(mem_write) |-> step[0]);
  assert_write_step_R8: assert property (@(posedge clk) disable iff (rst)
    mem_write |-> (step[5] && op_line[1]));
  assert_one_driver_R9: assert property (@(posedge clk) disable iff (rst)
    !(pc_out && acc_out));
endmodule

bind step_sequencer step_sequencer_chk u_chk (
  .clk(clk), .rst(rst), .step(step), .op_line(op_line),
  .pc_out(pc_out), .mar_load(mar_load), .ir_load(ir_load), .pc_inc(pc_inc),
  .acc_load(acc_load), .acc_out(acc_out), .mem_write(mem_write)
);

// File: tb/tb_step_sequencer.sv
module tb_step_sequencer;
  logic       clk = 0;
  logic       rst = 1;
  logic [7:0] ir_opcode = 8'd0;
  logic [5:0] step;
  logic [2:0] op_line;
  logic pc_out, mar_load, ir_load, pc_inc, acc_load, acc_out, mem_write;
  logic [6:0] strb;
  int checks = 0, fails = 0;
  bit mon_en = 0;

  typedef struct { logic [5:0] st; logic [6:0] sb; string tag; } item_t;
  item_t exp_q[$];
  logic [7:0] op_q[$];

  always #5 clk = ~clk;

  step_sequencer dut (
    .clk(clk), .rst(rst), .ir_opcode(ir_opcode), .step(step), .op_line(op_line),
    .pc_out(pc_out), .mar_load(mar_load), .ir_load(ir_load), .pc_inc(pc_inc),
    .acc_load(acc_load), .acc_out(acc_out), .mem_write(mem_write)
  );

  assign strb = {pc_out, mar_load, ir_load, pc_inc, acc_load, acc_out, mem_write};

  task automatic push(input logic [5:0] s, input logic [6:0] b, input string t);
    item_t it;
    it.st = s; it.sb = b; it.tag = t;
    exp_q.push_back(it);
  endtask

  task automatic issue(input logic [7:0] op);
    op_q.push_back(op);
    push(6'b000001, 7'b1100000, "R4");
    push(6'b000010, 7'b0010000, "R4");
    push(6'b000100, 7'b0001000, (op > 1) ? "R7" : "R4");
    if (op == 0) begin
      push(6'b001000, 7'b1100000, "R5");
      push(6'b010000, 7'b0001100, "R5");
    end else if (op == 1) begin
      push(6'b001000, 7'b1100000, "R6");
      push(6'b010000, 7'b0001000, "R6");
      push(6'b100000, 7'b0000011, "R6 R8");
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en && exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      check(step === it.st && strb === it.sb, it.tag, {3'b0, step, strb}, {3'b0, it.st, it.sb});
      if (step[5] || step[4]) check(!(pc_out && acc_out), "R9", {15'b0, acc_out}, 16'h0);
    end
  end

  always @(negedge clk) begin
    if (!rst && ir_load && op_q.size() > 0) ir_opcode = op_q.pop_front();
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(strb === 7'b0, "R1", {9'b0, strb}, 16'h0);
    check(step === 6'b000001, "R1", {10'b0, step}, 16'h1);
    for (int v = 0; v < 256; v++) begin
      logic [2:0] e;
      ir_opcode = v[7:0];
      #1;
      e = (v == 0) ? 3'b001 : (v == 1) ? 3'b010 : 3'b100;
      check(op_line === e, "R3", {13'b0, op_line}, {13'b0, e});
    end
    ir_opcode = 8'd0;
    issue(8'd0); issue(8'd1); issue(8'h7F); issue(8'd1); issue(8'hFF);
    issue(8'd0); issue(8'd0); issue(8'd1); issue(8'h02); issue(8'd0);
    @(negedge clk);
    rst = 0;
    mon_en = 1;
    #1;
    while (exp_q.size() > 0) @(posedge clk);
    mon_en = 0;
    @(negedge clk);
    while (!acc_load) @(negedge clk);
    rst = 1;
    #1;
    check(strb === 7'b0, "R1", {9'b0, strb}, 16'h0);
    @(negedge clk);
    check(step === 6'b000001 && strb === 7'b0, "R1", {3'b0, step, strb}, 16'h0080);
    rst = 0;
    #1;
    check(step === 6'b000001 && strb === 7'b1100000, "R1", {3'b0, step, strb}, 16'h00E0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule